// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked request port and an external 512K x 8 asynchronous static RAM. Each accepted request is a single byte read or write. The block drives the active-low chip select, output enable and write enable pins, holds the address, and drives or releases the bidirectional data bus through separate out, out-enable and in signals. Every timing limit of the memory is a parameter in nanoseconds. Each limit is rounded up to whole clock cycles at elaboration, with a floor of one cycle.

Writes are controlled by write enable, and output enable stays high throughout. Each write opens with a setup phase. In that phase chip select is low and the bus is undriven, which lets any earlier read data float away. Write enable is then pulsed low with the data driven. Write enable and the bus driver are released on the same edge. A read lowers chip select and output enable together, then latches the data bus when the access window closes. Completion is signalled by a one-cycle valid pulse. The request port is a valid/ready handshake, and ready stays low for the whole of an operation.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is asserted and after it is released, chip select, output enable and write enable are all high, the data bus is undriven, ready is high and read-valid is low.
- R2: Pin encoding is as follows. Idle means chip select is high. A read has chip select low, output enable low and write enable high. A write has chip select low, write enable low and output enable high. Output enable and write enable are never low together.
- R3: The memory address does not change while chip select and write enable are both low.
- R4: Each write enable low pulse lasts at least ceil(T_WP_NS/CLK_NS) cycles. At the defaults of 10 ns and 8 ns this is 2 cycles.
- R5: The data bus is driven only while write enable is low. It holds the request's write data for that whole time and is released on the edge where write enable rises.
- R6: Before write enable falls there is at least one cycle with chip select low, write enable high and the bus undriven.
- R7: A read latches the data bus ceil(T_ACC_NS/CLK_NS) cycles after chip select and output enable fall. That is 2 cycles at the defaults. The result appears on the read data output together with a read-valid pulse exactly one cycle wide.
- R8: Ready falls on the edge that accepts a request. It stays low for 3 cycles for a write and 2 cycles for a read at the defaults. A request presented while ready is low is not taken and leaves the memory unchanged.
- R9: A byte written to any address, including address 0 and the top address 0x7FFFF, is returned by a later read of that address. A second write to the same address replaces the earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken on this cycle's edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Data latched by the last read |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 19 | Memory address pins |
| mem_dq_o | output | 8 | Data bus value to drive |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Data bus value sensed |

## Verification
The memory model in the bench drives junk on the bus until two cycles of an active read have passed. A controller that latched one cycle early would therefore return wrong bytes. The model also flags a write that starts with the bus already driven, which is the turnaround case after a read. It flags a write enable pulse that is too short, an address that moves inside the write overlap, and output enable falling during a write. Each of these shows up as a corrupted stored byte or a model failure. A request held while the controller is busy would, if accepted, overwrite a byte that the bench later reads back. The busy-cycle counts expose a ready signal that returns too early.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WSETUP = 2'd1,
        ST_WPULSE = 2'd2,
        ST_READ   = 2'd3
    } ctl_state_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_IDLE   = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    localparam pin_ctl_t PINS_WSETUP = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    localparam pin_ctl_t PINS_WPULSE = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
    localparam pin_ctl_t PINS_READ   = '{cs_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};

    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    timer_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            vld  <= 1'b0;
        end else begin
            vld <= cap;
            if (cap) dout <= din;
        end
    end

    assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld);

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 8,
    parameter int T_ACC_NS = 15,
    parameter int T_CYC_NS = 15,
    parameter int T_OE_NS  = 7,
    parameter int T_WP_NS  = 10,
    parameter int T_DW_NS  = 7,
    parameter int T_HZ_NS  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int CYC_CYC = ns_to_cycles(T_CYC_NS, CLK_NS);
    localparam int SET_CYC = ns_to_cycles(T_HZ_NS, CLK_NS);
    localparam int ACC_CYC = imax(imax(ns_to_cycles(T_ACC_NS, CLK_NS),
                                       ns_to_cycles(T_OE_NS, CLK_NS)), CYC_CYC);
    localparam int WP_CYC  = imax(imax(ns_to_cycles(T_WP_NS, CLK_NS),
                                       ns_to_cycles(T_DW_NS, CLK_NS)),
                                  CYC_CYC - SET_CYC);
    localparam int MAX_CYC = imax(imax(ACC_CYC, WP_CYC), SET_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int WLC_W   = CNT_W + 1;

    ctl_state_e       state;
    pin_ctl_t         pins;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_zero;
    logic             rd_cap;

    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        case (state)
            ST_IDLE: begin
                t_load = req_valid;
                t_val  = req_write ? CNT_W'(SET_CYC - 1) : CNT_W'(ACC_CYC - 1);
            end
            ST_WSETUP: begin
                t_load = t_zero;
                t_val  = CNT_W'(WP_CYC - 1);
            end
            default: ;
        endcase
    end

    assign rd_cap    = (state == ST_READ) && t_zero;
    assign req_ready = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pins     <= PINS_IDLE;
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    mem_addr <= req_addr;
                    if (req_write) begin
                        mem_dq_o <= req_wdata;
                        state    <= ST_WSETUP;
                        pins     <= PINS_WSETUP;
                    end else begin
                        state <= ST_READ;
                        pins  <= PINS_READ;
                    end
                end
                ST_WSETUP: if (t_zero) begin
                    state <= ST_WPULSE;
                    pins  <= PINS_WPULSE;
                end
                ST_WPULSE: if (t_zero) begin
                    state <= ST_IDLE;
                    pins  <= PINS_IDLE;
                end
                ST_READ: if (t_zero) begin
                    state <= ST_IDLE;
                    pins  <= PINS_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                    pins  <= PINS_IDLE;
                end
            endcase
        end
    end

    assign mem_cs_n  = pins.cs_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.dq_oe;

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    sram_ctl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk  (clk),
        .rst  (rst),
        .cap  (rd_cap),
        .din  (mem_dq_i),
        .dout (rd_data),
        .vld  (rd_valid)
    );

    // Width checker for the write enable pulse
    logic [WLC_W-1:0] we_low_cnt;
    always_ff @(posedge clk) begin
        if (rst || mem_we_n) we_low_cnt <= '0;
        else                 we_low_cnt <= we_low_cnt + 1'b1;
    end

    assert_no_oe_we_overlap_R2: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    assert_strobes_need_cs_R2: assert property (@(posedge clk) disable iff (rst)
        mem_cs_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

    assert_addr_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !mem_we_n) |=> (mem_cs_n || mem_we_n || $stable(mem_addr)));

    assert_we_width_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_cnt >= WLC_W'(WP_CYC)));

    assert_drive_only_we_low_R5: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> !mem_we_n);

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(!mem_cs_n && !mem_dq_oe));

    assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> !req_ready);

endmodule

// File: tb/sram_async_ctl_tb.sv
module sram_async_ctl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [18:0] mem_addr;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    sram_async_ctl u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // ---------------- behavioural memory model ----------------
    logic [7:0]  mem [int];
    int          rd_age = 0;
    int          ovl_len = 0;
    logic [18:0] ovl_addr = '0;
    logic        p_cs_n = 1'b1, p_we_n = 1'b1, p_dq_oe = 1'b0;

    always_comb begin
        if (!mem_cs_n && !mem_oe_n && mem_we_n && rd_age >= 2)
            mem_dq_i = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
        else
            mem_dq_i = 8'hA5;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_age <= rd_age + 1;
            else rd_age <= 0;
            if (mem_dq_oe && mem_we_n) begin
                errors++; $display("FAIL R5 bus driven with we_n high: act=1 exp=0");
            end
            if (!mem_cs_n && !mem_we_n) begin
                if (!mem_oe_n) begin
                    errors++; $display("FAIL R2 oe_n low in write: act=0 exp=1");
                end
                if (ovl_len == 0) begin
                    checks++;
                    if (p_cs_n || !p_we_n || p_dq_oe) begin
                        errors++;
                        $display("FAIL R6 no turnaround: act cs_n=%0b we_n=%0b oe=%0b exp 0/1/0",
                                 p_cs_n, p_we_n, p_dq_oe);
                    end
                end else if (mem_addr != ovl_addr) begin
                    errors++; $display("FAIL R3 addr moved: act=%h exp=%h", mem_addr, ovl_addr);
                end
                if (!mem_dq_oe) begin
                    errors++; $display("FAIL R5 bus undriven during write: act=0 exp=1");
                end
                ovl_addr <= mem_addr;
                ovl_len  <= ovl_len + 1;
                mem[int'(mem_addr)] = mem_dq_o;
            end else begin
                if (ovl_len != 0) begin
                    checks++;
                    if (ovl_len < 2) begin
                        errors++; $display("FAIL R4 we pulse: act=%0d exp>=2", ovl_len);
                    end
                end
                ovl_len <= 0;
            end
            p_cs_n  <= mem_cs_n;
            p_we_n  <= mem_we_n;
            p_dq_oe <= mem_dq_oe;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input logic [18:0] a, input logic [7:0] d,
                         output logic [7:0] rdv, output int busy, output int pulses);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0; pulses = 0; rdv = 8'h00;
        for (int i = 0; i < 20 && !req_ready; i++) begin
            busy++;
            if (rd_valid) pulses++;
            @(negedge clk);
        end
        if (rd_valid) begin pulses++; rdv = rd_data; end
        @(negedge clk);
        if (rd_valid) pulses++;
    endtask

    // vector: [27]=write, [26:8]=address, [7:0]=data or expected read byte
    localparam int NVEC = 9;
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b1, 19'h00000, 8'h3C},
        {1'b1, 19'h7FFFF, 8'hC3},
        {1'b1, 19'h12345, 8'h5A},
        {1'b0, 19'h00000, 8'h3C},
        {1'b0, 19'h7FFFF, 8'hC3},
        {1'b0, 19'h12345, 8'h5A},
        {1'b1, 19'h12345, 8'hFF},
        {1'b0, 19'h12345, 8'hFF},
        {1'b0, 19'h7FFFF, 8'hC3}
    };

    initial begin
        logic [7:0] rv;
        int busy, pulses;
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 strobes in reset",
              {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !rd_valid && mem_cs_n && !mem_dq_oe, "R1 idle after reset",
              {req_ready, rd_valid, mem_cs_n, mem_dq_oe}, 4'b1010);

        for (int k = 0; k < NVEC; k++) begin
            do_op(VEC[k][27], VEC[k][26:8], VEC[k][7:0], rv, busy, pulses);
            if (VEC[k][27]) begin
                check(busy == 3, "R8 write busy cycles", busy, 3);
            end else begin
                check(busy == 2, "R8 read busy cycles", busy, 2);
                check(rv == VEC[k][7:0], "R7 R9 read data", rv, VEC[k][7:0]);
                check(pulses == 1, "R7 valid pulse width", pulses, 1);
            end
        end

        // R8: request held while busy must be ignored
        do_op(1'b1, 19'h00077, 8'h11, rv, busy, pulses);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00088; req_wdata = 8'h22;
        @(negedge clk);   // accepted here
        req_addr = 19'h00077; req_wdata = 8'h99;   // presented while ready low
        @(negedge clk);
        check(!req_ready, "R8 ready low while busy", req_ready, 0);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        do_op(1'b0, 19'h00077, 8'h00, rv, busy, pulses);
        check(rv == 8'h11, "R8 busy request ignored", rv, 8'h11);
        do_op(1'b0, 19'h00088, 8'h00, rv, busy, pulses);
        check(rv == 8'h22, "R9 accepted write stored", rv, 8'h22);

        // R6: write right after read, back to back
        do_op(1'b1, 19'h00001, 8'h81, rv, busy, pulses);
        do_op(1'b0, 19'h00001, 8'h00, rv, busy, pulses);
        check(rv == 8'h81, "R6 R9 write after read", rv, 8'h81);
        check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R2 idle encoding",
              {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule